// File: doc/BRIEF.md
# I2C Serial Memory Read Engine

This block is the read side of an I2C slave that fronts a byte-addressed serial memory. That memory has a 4096-byte main array and a separate 32-byte one-time-programmable (OTP) page. The engine takes already-synchronized SCL and SDA samples. It recognizes START and STOP and decodes the device-select byte, and it takes in the two address bytes of a random read. It then shifts stored bytes out, most significant bit first, for as long as the bus master keeps acknowledging. Data comes from a synchronous array through a registered address and a one-cycle read strobe. The read data is sampled one cycle after the strobe.

The main array and the OTP page each keep their own address pointer. The device-select byte picks between them: binary 1010_000d selects the main array and 1010_001d selects the OTP page, where d is the direction bit (1 = read). A write-direction select followed by two address bytes sets the pointer of the chosen space. A repeated START with the read direction then streams bytes from that pointer. The main pointer rolls over at the top of the array. The OTP pointer wraps inside its 32-byte page. One input, driven by protection logic outside the block, refuses the data bytes that a master tries to write into the OTP page.

Top module: `i2c_mem_rd_engine`

## Requirements
- R1: While reset is held and in the cycle after it, sda_pd_o, mem_rd_o and otp_rd_o are all low.
- R2: A device-select byte is acknowledged only if it matches 1010_00sd, where s selects the space (0 main, 1 OTP) and d is the direction. Any other device-select byte is not acknowledged, and the engine leaves SDA released until the next START.
- R3: A main-array random read loads a 12-bit address made of bits 3:0 of the first address byte (as the upper bits) and all of the second address byte. Output data is sent MSB first, and sda_pd_o changes only while SCL is low.
- R4: In a read, every master acknowledge in the 9th bit time makes the engine output the byte at the next address. The pointer advances by one after every byte that is output.
- R5: A sequential main-array read continues from address FFFh to address 000h.
- R6: A read without an address phase (current-address read) starts at the address after the last byte output in that space. The main pointer and the OTP pointer are independent.
- R7: The OTP pointer is set by device-select 1010_0010, then an address byte whose bits 3:0 are 0000, then an address byte whose bits 7:5 are 000. Bits 4:0 of the second address byte become the OTP pointer, and a repeated START with 1010_0011 reads from there.
- R8: A sequential OTP read continues from address 1Fh to address 00h.
- R9: If either OTP address check fails, every address and data byte is still acknowledged, but the OTP pointer keeps its previous value.
- R10: A high SDA in the master's 9th bit time ends the read. The engine releases SDA and drives nothing on further clocks until a START.
- R11: A START anywhere in a transfer restarts device-select reception, and an address phase that is cut short does not change the pointer. A STOP returns the engine to idle with SDA released.
- R12: While otp_lock_i is high, a data byte that follows an OTP address phase is not acknowledged. Main-array data bytes are still acknowledged, and the OTP address phase still sets the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample (wired-AND bus level) |
| otp_lock_i | input | 1 | High refuses data bytes written to the OTP page |
| sda_pd_o | output | 1 | Registered SDA pull-down enable |
| mem_rd_o | output | 1 | One-cycle main-array read strobe |
| mem_addr_o | output | 12 | Main-array read address, valid with the strobe |
| mem_rdata_i | input | 8 | Main-array data, valid the cycle after the strobe |
| otp_rd_o | output | 1 | One-cycle OTP read strobe |
| otp_addr_o | output | 5 | OTP read address, valid with the strobe |
| otp_rdata_i | input | 8 | OTP data, valid the cycle after the strobe |

## Verification
The bench acts as a bit-level bus master and drives random-address reads, current-address reads and multi-byte sequential reads in both spaces. Runs that start just below FFFh and at 1Eh show whether each space wraps on its own boundary. Current-address reads placed between traffic to the other space show whether the two pointers stay independent. Wrong device codes, failing OTP address checks, a master no-acknowledge followed by more clocks, an address phase cut by a repeated START, and the OTP lock input each set apart one refusal or abort path from normal operation.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } eng_state_t;

  typedef enum logic [1:0] {
    CX_DEV,
    CX_AMSB,
    CX_ALSB,
    CX_DATA
  } rx_ctx_t;

  typedef enum logic {
    SP_MAIN,
    SP_OTP
  } space_t;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = scl_i & ~scl_q;
    scl_fall  = ~scl_i & scl_q;
    start_det = scl_i & scl_q & sda_q & ~sda_i;
    stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2c_rd_pointer.sv
module i2c_rd_pointer #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (inc) begin
      ptr <= ptr + AW'(1);
    end
  end
endmodule

// File: rtl/i2c_rd_decode.sv
module i2c_rd_decode
  import i2c_rd_pkg::*;
#(
  parameter int          OTP_AW     = 5,
  parameter logic [3:0]  DEV_FAMILY = 4'b1010
) (
  input  rx_ctx_t    ctx,
  input  space_t     space_q,
  input  logic [7:0] rx_byte,
  input  logic       msb_ok_q,
  input  logic       otp_lock_i,
  output logic       ack,
  output logic       go_read,
  output space_t     space_new,
  output logic       main_load,
  output logic       otp_load,
  output logic       msb_ok_new,
  output rx_ctx_t    next_ctx
);
  always_comb begin
    ack        = 1'b0;
    go_read    = 1'b0;
    space_new  = space_q;
    main_load  = 1'b0;
    otp_load   = 1'b0;
    msb_ok_new = msb_ok_q;
    next_ctx   = CX_DATA;
    case (ctx)
      CX_DEV: begin
        if (rx_byte[7:4] == DEV_FAMILY && rx_byte[3:2] == 2'b00) begin
          ack       = 1'b1;
          space_new = rx_byte[1] ? SP_OTP : SP_MAIN;
          go_read   = rx_byte[0];
          next_ctx  = CX_AMSB;
        end
      end
      CX_AMSB: begin
        ack        = 1'b1;
        msb_ok_new = (rx_byte[3:0] == 4'b0000);
        next_ctx   = CX_ALSB;
      end
      CX_ALSB: begin
        ack = 1'b1;
        if (space_q == SP_MAIN) main_load = 1'b1;
        else otp_load = msb_ok_q && (rx_byte[7:OTP_AW] == '0);
      end
      default: begin
        ack = !(space_q == SP_OTP && otp_lock_i);
      end
    endcase
  end
endmodule

// File: rtl/i2c_mem_rd_engine.sv
module i2c_mem_rd_engine
  import i2c_rd_pkg::*;
#(
  parameter int         MEM_AW     = 12,
  parameter int         OTP_AW     = 5,
  parameter logic [3:0] DEV_FAMILY = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              otp_lock_i,
  output logic              sda_pd_o,
  output logic              mem_rd_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              otp_rd_o,
  output logic [OTP_AW-1:0] otp_addr_o,
  input  logic [7:0]        otp_rdata_i
);
  localparam int HI_W = MEM_AW - 8;

  logic scl_rise, scl_fall, start_det, stop_det;

  eng_state_t        state;
  rx_ctx_t           ctx;
  space_t            space_q;
  space_t            cap_space_q;
  logic [HI_W-1:0]   msb_q;
  logic              msb_ok_q;
  logic [7:0]        shreg;
  logic [7:0]        txsh;
  logic [7:0]        txbuf;
  logic [3:0]        bit_cnt;
  logic              read_q;
  logic              req_q;
  logic              cap_q;

  logic              dec_ack, dec_go_read, dec_main_load, dec_otp_load, dec_msb_ok;
  space_t            dec_space;
  rx_ctx_t           dec_next_ctx;

  logic              rx_done, tx_ack_rise;
  logic              main_load_en, otp_load_en, main_inc, otp_inc;
  logic [MEM_AW-1:0] main_ptr;
  logic [OTP_AW-1:0] otp_ptr;

  i2c_bus_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_rd_decode #(
    .OTP_AW    (OTP_AW),
    .DEV_FAMILY(DEV_FAMILY)
  ) u_decode (
    .ctx       (ctx),
    .space_q   (space_q),
    .rx_byte   (shreg),
    .msb_ok_q  (msb_ok_q),
    .otp_lock_i(otp_lock_i),
    .ack       (dec_ack),
    .go_read   (dec_go_read),
    .space_new (dec_space),
    .main_load (dec_main_load),
    .otp_load  (dec_otp_load),
    .msb_ok_new(dec_msb_ok),
    .next_ctx  (dec_next_ctx)
  );

  always_comb begin
    rx_done      = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
    tx_ack_rise  = (state == ST_TX_ACK) && scl_rise;
    main_load_en = rx_done && dec_main_load;
    otp_load_en  = rx_done && dec_otp_load;
    main_inc     = tx_ack_rise && (space_q == SP_MAIN);
    otp_inc      = tx_ack_rise && (space_q == SP_OTP);
  end

  i2c_rd_pointer #(.AW(MEM_AW)) u_main_ptr (
    .clk     (clk),
    .rst     (rst),
    .load    (main_load_en),
    .load_val({msb_q, shreg}),
    .inc     (main_inc),
    .ptr     (main_ptr)
  );

  i2c_rd_pointer #(.AW(OTP_AW)) u_otp_ptr (
    .clk     (clk),
    .rst     (rst),
    .load    (otp_load_en),
    .load_val(shreg[OTP_AW-1:0]),
    .inc     (otp_inc),
    .ptr     (otp_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ctx         <= CX_DEV;
      space_q     <= SP_MAIN;
      cap_space_q <= SP_MAIN;
      msb_q       <= '0;
      msb_ok_q    <= 1'b0;
      shreg       <= '0;
      txsh        <= '0;
      txbuf       <= '0;
      bit_cnt     <= '0;
      read_q      <= 1'b0;
      req_q       <= 1'b0;
      cap_q       <= 1'b0;
      sda_pd_o    <= 1'b0;
      mem_rd_o    <= 1'b0;
      mem_addr_o  <= '0;
      otp_rd_o    <= 1'b0;
      otp_addr_o  <= '0;
    end else begin
      // read pipeline: request -> strobe -> data capture
      mem_rd_o    <= 1'b0;
      otp_rd_o    <= 1'b0;
      req_q       <= 1'b0;
      cap_q       <= mem_rd_o | otp_rd_o;
      cap_space_q <= otp_rd_o ? SP_OTP : SP_MAIN;
      if (cap_q) txbuf <= (cap_space_q == SP_OTP) ? otp_rdata_i : mem_rdata_i;
      if (req_q) begin
        if (space_q == SP_OTP) begin
          otp_rd_o   <= 1'b1;
          otp_addr_o <= otp_ptr;
        end else begin
          mem_rd_o   <= 1'b1;
          mem_addr_o <= main_ptr;
        end
      end

      if (start_det) begin
        state    <= ST_RX;
        ctx      <= CX_DEV;
        bit_cnt  <= '0;
        read_q   <= 1'b0;
        sda_pd_o <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pd_o <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_i};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (rx_done) begin
              if (dec_ack) begin
                sda_pd_o <= 1'b1;
                state    <= ST_RX_ACK;
                ctx      <= dec_next_ctx;
                space_q  <= dec_space;
                msb_ok_q <= dec_msb_ok;
                read_q   <= dec_go_read;
                req_q    <= dec_go_read;
                if (ctx == CX_AMSB) msb_q <= shreg[HI_W-1:0];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              if (read_q) begin
                state    <= ST_TX;
                txsh     <= txbuf;
                sda_pd_o <= ~txbuf[7];
                bit_cnt  <= 4'd1;
              end else begin
                state    <= ST_RX;
                sda_pd_o <= 1'b0;
                bit_cnt  <= '0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_pd_o <= 1'b0;
                state    <= ST_TX_ACK;
              end else begin
                sda_pd_o <= ~txsh[6];
                txsh     <= {txsh[6:0], 1'b1};
                bit_cnt  <= bit_cnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (!sda_i) begin
                state <= ST_RX_ACK;
                req_q <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_rd_checker.sv
module i2c_mem_rd_checker (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_i,
  input logic sda_pd_o,
  input logic mem_rd_o,
  input logic otp_rd_o
);
  logic rst_q;

  always_ff @(posedge clk) rst_q <= rst;

  // R1: outputs quiet once reset has been seen on an edge
  always_comb begin
    if (rst_q && rst) begin
      a_r1_quiet_in_reset: assert (!sda_pd_o && !mem_rd_o && !otp_rd_o);
    end
  end

  // R3: pull-down only moves after SCL was low
  a_r3_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pd_o) |-> !$past(scl_i));

  // R4: each read strobe is a single-cycle pulse
  a_r4_mem_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |=> !mem_rd_o);

  a_r4_otp_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    otp_rd_o |=> !otp_rd_o);

  // R6: the two spaces are never read in the same cycle
  a_r6_one_space: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd_o, otp_rd_o}));

  // R11: after a START the bus is released
  a_r11_start_releases: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> !sda_pd_o);
endmodule

bind i2c_mem_rd_engine i2c_mem_rd_checker u_chk (.*);

// File: tb/i2c_mem_rd_engine_bench.sv
`timescale 1ns/1ps
module i2c_mem_rd_engine_bench;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        scl_m, sda_m, lock;
  logic        sda_bus;
  logic        sda_pd, mem_rd, otp_rd;
  logic [11:0] mem_addr;
  logic [4:0]  otp_addr;
  logic [7:0]  mem_rdata, otp_rdata;

  int checks = 0;
  int errors = 0;
  int ref_main = 0;
  int ref_otp = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pd;

  i2c_mem_rd_engine u_i2c_mem_rd_engine (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .otp_lock_i (lock),
    .sda_pd_o   (sda_pd),
    .mem_rd_o   (mem_rd),
    .mem_addr_o (mem_addr),
    .mem_rdata_i(mem_rdata),
    .otp_rd_o   (otp_rd),
    .otp_addr_o (otp_addr),
    .otp_rdata_i(otp_rdata)
  );

  function automatic logic [7:0] mem_f(int a);
    return 8'(((a * 37) + (a >> 5) + 11) & 255);
  endfunction

  function automatic logic [7:0] otp_f(int a);
    return 8'(((a * 13) + 90) & 255);
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_f(int'(mem_addr));
    if (otp_rd) otp_rdata <= otp_f(int'(otp_addr));
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock monitor: SDA pull-down may only move while SCL is low (R3)
  logic pd_prev = 1'b0;
  always @(negedge clk) begin
    if (rst === 1'b0 && sda_pd !== pd_prev) begin
      checks++;
      if (scl_m) begin
        errors++;
        $display("FAIL R3 sda moved with SCL high: actual %0b expected %0b", sda_pd, pd_prev);
      end
    end
    pd_prev <= sda_pd;
  end

  task automatic wait_c(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wait_c(H);
    scl_m = 1'b1; wait_c(H);
    sda_m = 1'b0; wait_c(H);
    scl_m = 1'b0; wait_c(2);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wait_c(H);
    scl_m = 1'b1; wait_c(H);
    sda_m = 1'b1; wait_c(H);
  endtask

  task automatic clk_bit(input bit b, output bit smp);
    sda_m = b; wait_c(H);
    scl_m = 1'b1; wait_c(H / 2);
    smp = sda_bus; wait_c(H / 2);
    scl_m = 1'b0; wait_c(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!mack, s);
  endtask

  task automatic tx(string tag, logic [7:0] b, bit exp_ack);
    bit a;
    send_byte(b, a);
    chk(tag, int'(a), int'(exp_ack));
  endtask

  task automatic rd_main(string tag, int n);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk(tag, int'(d), int'(mem_f(ref_main)));
      ref_main = (ref_main + 1) % 4096;
    end
  endtask

  task automatic rd_otp(string tag, int n);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk(tag, int'(d), int'(otp_f(ref_otp)));
      ref_otp = (ref_otp + 1) % 32;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit s;
    logic [7:0] d;
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; lock = 1'b0;
    wait_c(5);
    chk("R1 sda_pd in reset", int'(sda_pd), 0);
    chk("R1 strobes in reset", int'(mem_rd | otp_rd), 0);
    rst = 1'b0;
    wait_c(1);
    chk("R1 sda_pd after reset", int'(sda_pd), 0);

    // R3 R4: random main read at 123h, three bytes
    m_start();
    tx("R2 main write select ack", 8'hA0, 1'b1);
    tx("R3 addr msb ack", 8'hF1, 1'b1);
    tx("R3 addr lsb ack", 8'h23, 1'b1);
    ref_main = 12'h123;
    m_start();
    tx("R2 main read select ack", 8'hA1, 1'b1);
    rd_main("R4 sequential main data", 3);
    m_stop();

    // R6 current address read
    m_start();
    tx("R6 current read select", 8'hA1, 1'b1);
    rd_main("R6 current main data", 1);
    m_stop();

    // R5 rollover
    m_start();
    tx("R5 select", 8'hA0, 1'b1);
    tx("R5 msb", 8'h0F, 1'b1);
    tx("R5 lsb", 8'hFE, 1'b1);
    ref_main = 12'hFFE;
    m_start();
    tx("R5 read select", 8'hA1, 1'b1);
    rd_main("R5 rollover data", 3);
    m_stop();

    // R7 R8 OTP random read across wrap
    m_start();
    tx("R7 otp select", 8'hA2, 1'b1);
    tx("R7 otp msb", 8'h00, 1'b1);
    tx("R7 otp lsb", 8'h1E, 1'b1);
    ref_otp = 5'h1E;
    m_start();
    tx("R7 otp read select", 8'hA3, 1'b1);
    rd_otp("R8 otp wrap data", 4);
    m_stop();

    // R6 pointers independent
    m_start();
    tx("R6 main after otp select", 8'hA1, 1'b1);
    rd_main("R6 main pointer kept", 1);
    m_stop();
    m_start();
    tx("R6 otp current select", 8'hA3, 1'b1);
    rd_otp("R6 otp pointer kept", 1);
    m_stop();

    // R9 failing OTP address checks
    m_start();
    tx("R9 select", 8'hA2, 1'b1);
    tx("R9 bad msb still acked", 8'h01, 1'b1);
    tx("R9 lsb acked", 8'h05, 1'b1);
    tx("R9 data acked", 8'h55, 1'b1);
    m_stop();
    m_start();
    tx("R9 read select", 8'hA3, 1'b1);
    rd_otp("R9 pointer unchanged (msb)", 1);
    m_stop();
    m_start();
    tx("R9 select b", 8'hA2, 1'b1);
    tx("R9 msb b", 8'h00, 1'b1);
    tx("R9 bad lsb still acked", 8'h25, 1'b1);
    m_stop();
    m_start();
    tx("R9 read select b", 8'hA3, 1'b1);
    rd_otp("R9 pointer unchanged (lsb)", 1);
    m_stop();

    // R2 foreign device codes
    m_start();
    tx("R2 foreign code nack", 8'hB0, 1'b0);
    tx("R2 later byte ignored", 8'h00, 1'b0);
    m_stop();
    m_start();
    tx("R2 bits 3:2 nonzero nack", 8'hA5, 1'b0);
    m_stop();

    // R10 no-ack ends the read; later clocks see a released bus
    m_start();
    tx("R10 select", 8'hA1, 1'b1);
    rd_main("R10 last data", 1);
    d = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    chk("R10 bus released after nack", int'(d), 8'hFF);
    m_stop();

    // R11 address phase cut by repeated start, and by stop
    m_start();
    tx("R11 select", 8'hA0, 1'b1);
    tx("R11 msb", 8'h03, 1'b1);
    m_start();
    tx("R11 read after abort", 8'hA1, 1'b1);
    rd_main("R11 pointer unchanged by abort", 1);
    m_stop();
    m_start();
    tx("R11 select b", 8'hA0, 1'b1);
    tx("R11 msb b", 8'h07, 1'b1);
    m_stop();
    chk("R11 released after stop", int'(sda_pd), 0);
    m_start();
    tx("R11 read after stop", 8'hA1, 1'b1);
    rd_main("R11 pointer unchanged by stop", 1);
    m_stop();

    // R12 OTP lock
    lock = 1'b1;
    m_start();
    tx("R12 otp select", 8'hA2, 1'b1);
    tx("R12 otp msb", 8'h00, 1'b1);
    tx("R12 otp lsb", 8'h03, 1'b1);
    ref_otp = 3;
    tx("R12 otp data refused", 8'h5A, 1'b0);
    m_stop();
    m_start();
    tx("R12 main select", 8'hA0, 1'b1);
    tx("R12 main msb", 8'h00, 1'b1);
    tx("R12 main lsb", 8'h10, 1'b1);
    ref_main = 12'h010;
    tx("R12 main data acked", 8'h77, 1'b1);
    m_stop();
    lock = 1'b0;
    m_start();
    tx("R12 otp read select", 8'hA3, 1'b1);
    rd_otp("R12 otp pointer set under lock", 2);
    m_stop();
    m_start();
    tx("R12 main read select", 8'hA1, 1'b1);
    rd_main("R12 main pointer set", 1);
    m_stop();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule